// File: doc/BRIEF.md
# Multi-Address I2C Slave Address Matcher

This block decides whether the first byte of an I2C transfer (the byte that follows a START or repeated START) is aimed at this device. It holds four own-address slots. Each slot has a 7-bit address, a general-call enable bit and a 7-bit ignore mask. It receives the assembled byte and a strobe from an upstream shift register, and reports an own-address hit, the index of the slot that hit, a general-call hit and an interrupt request.

The matched byte is latched and held so that software can see which address was actually seen on the bus, which matters when masks let one slot answer to a range of addresses. Bit 0 of that byte, the read/write direction, is brought out on its own pin. Status stays set until a clear pulse. The slots are loaded through a small write port. Bus timing, START/STOP detection, acknowledge generation and the data phase belong to neighbouring logic.

Top module: `i2c_addr_matcher`

## Requirements
- R1: A synchronous reset clears all slots (address, ignore mask and general-call enable), all flags and the latched byte. With every slot cleared, no received byte raises any flag.
- R2: A write with `cfg_mask`=0 loads slot `cfg_idx` with address `cfg_wdata[7:1]` and general-call enable `cfg_wdata[0]`. A write with `cfg_mask`=1 loads that slot's ignore mask from `cfg_wdata[7:1]`. A slot hits when received bits 7:1 equal its address in every bit position whose ignore bit is 0. Received bit 0 never takes part in the comparison.
- R3: The received byte 0x00 sets `gc_hit` if at least one slot has its general-call enable set, and never sets `hit`. The byte 0x01 is not a general call.
- R4: A slot whose address field is 0000000 never produces an own-address hit, whatever its mask.
- R5: When several slots hit the same byte, `hit_slot` reports the lowest-numbered one.
- R6: A byte is evaluated only when `rx_valid` and `rx_first` are both high. A byte strobed with `rx_first`=0 changes no output.
- R7: Flags appear in the cycle after the clock edge that samples the strobe, and `irq` is high exactly when `hit` or `gc_hit` is high.
- R8: On a hit, `rx_hold` latches the whole received byte and `rw_dir` shows its bit 0. A byte that causes no hit leaves `rx_hold` unchanged.
- R9: Flags stay set until `clr` is pulsed. While `irq` is pending, later hits change neither `hit_slot` nor `rx_hold`. A `clr` that arrives in the same cycle as a hitting strobe clears the old status, and the new hit loads. After a clear, `hit_slot` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mask | input | 1 | 0 selects address/enable, 1 selects ignore mask |
| cfg_idx | input | 2 | Slot index written |
| cfg_wdata | input | 8 | Write data, bits 7:1 field, bit 0 general-call enable |
| rx_byte | input | 8 | Byte from the receive shift register |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` is complete |
| rx_first | input | 1 | Marks the byte as the first after a START |
| clr | input | 1 | Clears the status flags |
| hit | output | 1 | Own-address hit |
| gc_hit | output | 1 | General-call hit |
| hit_slot | output | 2 | Lowest slot index that hit |
| irq | output | 1 | Interrupt request |
| rw_dir | output | 1 | Direction bit of the latched byte |
| rx_hold | output | 8 | Latched received address byte |

## Verification
The hardest states to reach are those where two events fall on the same edge. One is a clear pulse that lands on the same edge as a new hitting strobe. Another is a second hitting address that arrives while a previous hit is still pending. The stimulus lines these up on purpose by driving `clr` and the strobe at the same negative edge, and by sending a second matching byte before clearing. Overlapping masked slots, and a reserved all-zero slot with a full mask, are exercised by sweeping all 256 byte values against several slot configurations.

// File: rtl/i2c_match_pkg.sv
package i2c_match_pkg;

    localparam int unsigned SLOTS     = 4;
    localparam int unsigned ADDR_BITS = 7;
    localparam int unsigned BYTE_BITS = ADDR_BITS + 1;

    typedef logic [ADDR_BITS-1:0] addr_t;
    typedef logic [BYTE_BITS-1:0] byte_t;

    // One own-address slot as seen by the comparators.
    typedef struct packed {
        addr_t addr;
        logic  gc_en;
        addr_t ign;
    } slot_cfg_t;

    // Address field equality with ignored positions dropped.
    function automatic logic field_eq(input addr_t own, input addr_t ign, input addr_t seen);
        return ((own ^ seen) & ~ign) == '0;
    endfunction

endpackage

// File: rtl/i2c_addr_cfg.sv
module i2c_addr_cfg
    import i2c_match_pkg::*;
#(
    parameter int unsigned NSLOT = SLOTS,
    parameter int unsigned IDX_W = $clog2(NSLOT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic                   sel_mask,
    input  logic [IDX_W-1:0]       idx,
    input  byte_t                  wdata,
    output slot_cfg_t [NSLOT-1:0]  cfg
);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        slot_cfg_t r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                if (sel_mask) begin
                    r.ign <= wdata[BYTE_BITS-1:1];
                end else begin
                    r.addr  <= wdata[BYTE_BITS-1:1];
                    r.gc_en <= wdata[0];
                end
            end
        end
        assign cfg[g] = r;
    end

endmodule

// File: rtl/i2c_slot_cmp.sv
module i2c_slot_cmp
    import i2c_match_pkg::*;
(
    input  slot_cfg_t cfg,
    input  byte_t     rx,
    output logic      own_eq
);

    logic reserved;
    logic gc_byte;

    always_comb begin
        reserved = (cfg.addr == '0);
        gc_byte  = (rx == '0);
        own_eq   = !reserved && !gc_byte && field_eq(cfg.addr, cfg.ign, rx[BYTE_BITS-1:1]);
    end

endmodule

// File: rtl/i2c_lowest_pick.sv
module i2c_lowest_pick #(
    parameter int unsigned N = 4,
    parameter int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
        any = |req;
    end

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import i2c_match_pkg::*;
#(
    parameter int unsigned NSLOT = SLOTS,
    localparam int unsigned IDX_W = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_mask,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [7:0]       cfg_wdata,
    input  logic [7:0]       rx_byte,
    input  logic             rx_valid,
    input  logic             rx_first,
    input  logic             clr,
    output logic             hit,
    output logic             gc_hit,
    output logic [IDX_W-1:0] hit_slot,
    output logic             irq,
    output logic             rw_dir,
    output logic [7:0]       rx_hold
);

    slot_cfg_t [NSLOT-1:0] cfg;
    logic [NSLOT-1:0]      own_eq;
    logic [NSLOT-1:0]      gc_vec;
    logic                  own_any;
    logic [IDX_W-1:0]      own_idx;
    logic                  gc_want;
    logic                  eval;
    logic                  pending;

    i2c_addr_cfg #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .sel_mask (cfg_mask),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .cfg      (cfg)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        i2c_slot_cmp u_cmp (
            .cfg    (cfg[g]),
            .rx     (rx_byte),
            .own_eq (own_eq[g])
        );
        assign gc_vec[g] = cfg[g].gc_en;
    end

    i2c_lowest_pick #(.N(NSLOT), .W(IDX_W)) u_pick (
        .req (own_eq),
        .any (own_any),
        .idx (own_idx)
    );

    always_comb begin
        gc_want = (rx_byte == '0) && (|gc_vec);
        eval    = rx_valid && rx_first;
        pending = (hit || gc_hit) && !clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit      <= 1'b0;
            gc_hit   <= 1'b0;
            hit_slot <= '0;
            rx_hold  <= '0;
        end else begin
            if (clr) begin
                hit      <= 1'b0;
                gc_hit   <= 1'b0;
                hit_slot <= '0;
            end
            if (eval && !pending && (own_any || gc_want)) begin
                hit      <= own_any;
                gc_hit   <= gc_want;
                hit_slot <= own_any ? own_idx : '0;
                rx_hold  <= rx_byte;
            end
        end
    end

    assign irq    = hit || gc_hit;
    assign rw_dir = rx_hold[0];

endmodule

// File: rtl/i2c_addr_matcher_chk.sv
module i2c_addr_matcher_chk (
    input logic       clk,
    input logic       rst,
    input logic       clr,
    input logic       rx_valid,
    input logic       rx_first,
    input logic       hit,
    input logic       gc_hit,
    input logic [1:0] hit_slot,
    input logic       irq,
    input logic [7:0] rx_hold
);

    assert_one_kind_R3: assert property (@(posedge clk) disable iff (rst)
        !(hit && gc_hit));

    assert_gc_zero_byte_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(gc_hit) |-> rx_hold == 8'h00);

    assert_only_first_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(rx_valid && rx_first));

    assert_hold_moves_on_hit_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_hold) |-> irq);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> (irq && $stable(hit_slot) && $stable(rx_hold)));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr && !(rx_valid && rx_first)) |=> (!irq && hit_slot == 2'd0));

endmodule

bind i2c_addr_matcher i2c_addr_matcher_chk u_chk (.*);

// File: tb/i2c_addr_matcher_test.sv
`timescale 1ns/1ps
module i2c_addr_matcher_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0, cfg_mask = 1'b0;
    logic [1:0] cfg_idx = '0;
    logic [7:0] cfg_wdata = '0, rx_byte = '0;
    logic       rx_valid = 1'b0, rx_first = 1'b0, clr = 1'b0;
    logic       hit, gc_hit, irq, rw_dir;
    logic [1:0] hit_slot;
    logic [7:0] rx_hold;

    int n_chk = 0;
    int n_fail = 0;

    logic [6:0] m_addr [4];
    logic [6:0] m_ign  [4];
    logic       m_gc   [4];
    logic [7:0] exp_hold;

    i2c_addr_matcher uut (.*);

    always #10 clk = ~clk;

    task automatic check(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int idx, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mask = sel; cfg_idx = 2'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_ign[idx] = d[7:1];
        else begin m_addr[idx] = d[7:1]; m_gc[idx] = d[0]; end
    endtask

    task automatic send(input logic [7:0] b, input logic first, input logic with_clr);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1; rx_first = first; clr = with_clr;
        @(negedge clk);
        rx_valid = 1'b0; rx_first = 1'b0; clr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic model(input logic [7:0] b, output logic own, output logic gc, output logic [1:0] s);
        own = 1'b0; gc = 1'b0; s = 2'd0;
        if (b == 8'h00) begin
            for (int i = 0; i < 4; i++) if (m_gc[i]) gc = 1'b1;
        end else begin
            for (int i = 0; i < 4; i++)
                if (!own && m_addr[i] != 7'd0 && ((m_addr[i] ^ b[7:1]) & ~m_ign[i]) == 7'd0) begin
                    own = 1'b1; s = 2'(i);
                end
        end
    endtask

    // R2 R3 R4 R5 R7 R8: sweep every byte value against the current slots
    task automatic sweep(input string tag);
        logic own, gc;
        logic [1:0] s;
        for (int b = 0; b < 256; b++) begin
            model(8'(b), own, gc, s);
            send(8'(b), 1'b1, 1'b0);
            if (own || gc) exp_hold = 8'(b);
            check(hit, own, {tag, " R2/R4 hit"});
            check(gc_hit, gc, {tag, " R3 gc_hit"});
            check(hit_slot, s, {tag, " R5 hit_slot"});
            check(irq, own | gc, {tag, " R7 irq"});
            check(rx_hold, exp_hold, {tag, " R8 rx_hold"});
            check(rw_dir, exp_hold[0], {tag, " R8 rw_dir"});
            if (own || gc) begin
                pulse_clr();
                check(irq, 0, {tag, " R9 cleared"});
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_addr[i] = '0; m_ign[i] = '0; m_gc[i] = 1'b0; end
        exp_hold = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(hit, 0, "R1 hit");
        check(gc_hit, 0, "R1 gc_hit");
        check(irq, 0, "R1 irq");
        check(hit_slot, 0, "R1 hit_slot");
        check(rx_hold, 0, "R1 rx_hold");
        sweep("R1 cleared slots");

        // Overlapping masks, reserved slot with full mask and gc enable
        wr(1'b0, 0, {7'h50, 1'b0});
        wr(1'b0, 1, {7'h20, 1'b0}); wr(1'b1, 1, {7'h0F, 1'b0});
        wr(1'b0, 2, {7'h24, 1'b1});
        wr(1'b0, 3, {7'h00, 1'b0}); wr(1'b1, 3, {7'h7F, 1'b0});
        sweep("cfgA");

        // No gc enable; wildcard slot 2 loses priority to slot 0
        wr(1'b0, 0, {7'h3C, 1'b0}); wr(1'b1, 0, {7'h00, 1'b0});
        wr(1'b0, 2, {7'h7F, 1'b0}); wr(1'b1, 2, {7'h7F, 1'b0});
        wr(1'b0, 1, {7'h11, 1'b0}); wr(1'b1, 1, {7'h00, 1'b0});
        sweep("cfgB");

        // R6: first=0 byte that would hit changes nothing
        send(8'h79, 1'b0, 1'b0);
        check(irq, 0, "R6 data byte irq");
        check(rx_hold, exp_hold, "R6 data byte rx_hold");

        // R9: sticky status, later hit ignored while pending
        send(8'h78, 1'b1, 1'b0);
        check(hit_slot, 0, "R9 first hit slot");
        check(rx_hold, 8'h78, "R9 first hit byte");
        send(8'h23, 1'b1, 1'b0);
        check(hit_slot, 0, "R9 pending slot kept");
        check(rx_hold, 8'h78, "R9 pending byte kept");
        check(irq, 1, "R9 irq stays");
        // R9: clear together with a new hitting strobe loads the new hit
        send(8'h23, 1'b1, 1'b1);
        check(hit, 1, "R9 clr+strobe hit");
        check(hit_slot, 1, "R9 clr+strobe slot");
        check(rx_hold, 8'h23, "R9 clr+strobe byte");
        check(rw_dir, 1, "R8 rw_dir read");
        pulse_clr();
        check(irq, 0, "R9 final clear");
        check(hit_slot, 0, "R9 slot after clear");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule